// File: doc/BRIEF.md
# Request/Acknowledge Clock-Domain Bridge

This block moves one bus transaction at a time from a source clock domain into an unrelated system clock domain, then brings the completion and a 32-bit response word back. The source side raises a single-cycle request strobe together with a packed request word. The bridge holds that word and signals the crossing by flipping a level. In the system domain it presents an address, write data and a one-cycle write or read strobe. It then samples the read data and flips a second level back. The source side sees a one-cycle acknowledge with the response word.

Only one transaction can be in flight. A request that arrives while the bridge is still waiting for its acknowledge is dropped. The producer is expected to wait for the acknowledge before it issues the next request.

Top module: `xdom_req_bridge`

## Requirements
- R1: After reset the acknowledge, both system strobes, the system address and the response word are all zero.
- R2: The request word is laid out from its top bit down as follows: write flag at bit 50, read flag at bit 49, a 3-bit high address part at bits 48:46, a 14-bit low address part at bits 45:32, and write data at bits 31:0. The system address is the high part followed by the low part.
- R3: A request with the write flag set produces exactly one write strobe, no read strobe, and system write data equal to bits 31:0 of the request word.
- R4: A request with the read flag set produces exactly one read strobe and no write strobe, even when its data field is non-zero.
- R5: Each system strobe is high for exactly one system clock cycle.
- R6: Read data is sampled in the system cycle that follows the read strobe. That value is the response word delivered with the acknowledge.
- R7: Every accepted request yields exactly one acknowledge, one source cycle wide. The response word holds its value until the next acknowledge.
- R8: A request strobe that arrives while a transaction is outstanding is ignored. It causes no strobe, no extra acknowledge and no change of the pending address. Once the acknowledge has been delivered, a later request is accepted.
- R9: R3 to R7 hold whether the source clock is slower or faster than the system clock.
- R10: The system address and write data keep their values after the strobe until the next accepted request is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain reset, active low |
| reqPulse | input | 1 | One-cycle request strobe |
| reqBundle | input | 51 | Packed request word (flags, address, write data) |
| ackPulse | output | 1 | One-cycle acknowledge in the source domain |
| rspWord | output | 32 | Response word, valid from the acknowledge onward |
| sysClk | input | 1 | System domain clock |
| sysRstN | input | 1 | System domain reset, active low |
| sysAddr | output | 17 | Transaction address |
| sysWrStb | output | 1 | One-cycle write strobe |
| sysWrData | output | 32 | Write data |
| sysRdStb | output | 1 | One-cycle read strobe |
| sysRdData | input | 32 | Read data, sampled the cycle after the read strobe |

## Verification
The responder in the bench puts valid read data on its bus only during the cycle after the read strobe and drives filler at every other time. A bridge that samples a cycle early or late therefore returns the wrong response word. Read requests are issued with data fields full of ones, so a bridge that lets the data field or the wrong flag raise a write strobe shows up as an extra write count. A second request is fired while the first is still outstanding; a bridge without the busy guard would show a second strobe, a second acknowledge or a replaced address. Every vector runs at a source clock that is slower than, close to, or faster than the system clock. This exposes an edge detector that drops or doubles a toggle, or an acknowledge pulse longer than one cycle.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
  // Strobes from the handshake control to the datapath.
  typedef struct packed {
    logic loadReq;   // source domain: capture request word
    logic dispatch;  // system domain: present address/data/strobe
    logic capture;   // system domain: sample read data
    logic deliver;   // source domain: publish response word
  } xbrStrb_t;
endpackage

// File: rtl/xbr_sync.sv
module xbr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/xbr_ctrl.sv
module xbr_ctrl
  import xbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     srcClk,
  input  logic     srcRstN,
  input  logic     reqPulse,
  input  logic     sysClk,
  input  logic     sysRstN,
  output xbrStrb_t strb,
  output logic     ackPulse
);
  // source side state
  logic busy, reqTog, ackSeen, ackPrev, ackEvent, loadReq;
  // system side state
  logic reqSeen, reqPrev, reqEvent, dispQ, capQ, ackTog;

  assign loadReq  = reqPulse & ~busy;
  assign ackEvent = ackSeen ^ ackPrev;
  assign reqEvent = reqSeen ^ reqPrev;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      busy     <= 1'b0;
      reqTog   <= 1'b0;
      ackPrev  <= 1'b0;
      ackPulse <= 1'b0;
    end else begin
      if (loadReq) begin
        reqTog <= ~reqTog;
        busy   <= 1'b1;
      end else if (ackEvent) begin
        busy <= 1'b0;
      end
      ackPrev  <= ackSeen;
      ackPulse <= ackEvent;
    end
  end

  xbr_sync #(.STAGES(SYNC_STAGES)) i_reqSync (
    .clk(sysClk), .rstN(sysRstN), .din(reqTog), .dout(reqSeen)
  );

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      reqPrev <= 1'b0;
      dispQ   <= 1'b0;
      capQ    <= 1'b0;
      ackTog  <= 1'b0;
    end else begin
      reqPrev <= reqSeen;
      dispQ   <= reqEvent;  // strobe cycle
      capQ    <= dispQ;     // read data cycle
      if (capQ) ackTog <= ~ackTog;
    end
  end

  xbr_sync #(.STAGES(SYNC_STAGES)) i_ackSync (
    .clk(srcClk), .rstN(srcRstN), .din(ackTog), .dout(ackSeen)
  );

  always_comb begin
    strb          = '0;
    strb.loadReq  = loadReq;
    strb.dispatch = reqEvent;
    strb.capture  = capQ;
    strb.deliver  = ackEvent;
  end

  // R7
  ack_single_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    ackPulse |=> !ackPulse);

  // R8
  no_retoggle_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    busy |=> $stable(reqTog));
endmodule

// File: rtl/xbr_dp.sv
module xbr_dp
  import xbr_pkg::*;
#(
  parameter int ADDR_HI_W = 3,
  parameter int ADDR_LO_W = 14,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = ADDR_HI_W + ADDR_LO_W,
  localparam int PAY_W    = 2 + ADDR_W + DATA_W
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  xbrStrb_t          strb,
  input  logic [PAY_W-1:0]  reqBundle,
  output logic [DATA_W-1:0] rspWord,
  output logic [ADDR_W-1:0] sysAddr,
  output logic              sysWrStb,
  output logic [DATA_W-1:0] sysWrData,
  output logic              sysRdStb,
  input  logic [DATA_W-1:0] sysRdData
);
  localparam int WR_BIT = PAY_W - 1;
  localparam int RD_BIT = PAY_W - 2;

  logic [PAY_W-1:0]  payload;
  logic [DATA_W-1:0] rspHold;

  // source domain: request holding and response publishing
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      payload <= '0;
      rspWord <= '0;
    end else begin
      if (strb.loadReq) payload <= reqBundle;
      if (strb.deliver) rspWord <= rspHold;
    end
  end

  // system domain: dispatch and read capture
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysAddr   <= '0;
      sysWrData <= '0;
      sysWrStb  <= 1'b0;
      sysRdStb  <= 1'b0;
      rspHold   <= '0;
    end else begin
      sysWrStb <= strb.dispatch & payload[WR_BIT];
      sysRdStb <= strb.dispatch & payload[RD_BIT];
      if (strb.dispatch) begin
        sysAddr   <= payload[DATA_W +: ADDR_W];
        sysWrData <= payload[DATA_W-1:0];
      end
      if (strb.capture) rspHold <= sysRdData;
    end
  end

  // R5
  wr_pulse_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysWrStb |=> !sysWrStb);

  // R5
  rd_pulse_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysRdStb |=> !sysRdStb);

  // R10
  addr_hold_chk: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (sysRdStb || sysWrStb) |=> $stable(sysAddr) && $stable(sysWrData));
endmodule

// File: rtl/xdom_req_bridge.sv
module xdom_req_bridge
  import xbr_pkg::*;
#(
  parameter int ADDR_HI_W   = 3,
  parameter int ADDR_LO_W   = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = ADDR_HI_W + ADDR_LO_W,
  localparam int PAY_W      = 2 + ADDR_W + DATA_W
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              reqPulse,
  input  logic [PAY_W-1:0]  reqBundle,
  output logic              ackPulse,
  output logic [DATA_W-1:0] rspWord,
  input  logic              sysClk,
  input  logic              sysRstN,
  output logic [ADDR_W-1:0] sysAddr,
  output logic              sysWrStb,
  output logic [DATA_W-1:0] sysWrData,
  output logic              sysRdStb,
  input  logic [DATA_W-1:0] sysRdData
);
  xbrStrb_t strb;

  xbr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .reqPulse(reqPulse),
    .sysClk(sysClk), .sysRstN(sysRstN), .strb(strb), .ackPulse(ackPulse)
  );

  xbr_dp #(.ADDR_HI_W(ADDR_HI_W), .ADDR_LO_W(ADDR_LO_W), .DATA_W(DATA_W)) i_dp (
    .srcClk(srcClk), .srcRstN(srcRstN), .sysClk(sysClk), .sysRstN(sysRstN),
    .strb(strb), .reqBundle(reqBundle), .rspWord(rspWord),
    .sysAddr(sysAddr), .sysWrStb(sysWrStb), .sysWrData(sysWrData),
    .sysRdStb(sysRdStb), .sysRdData(sysRdData)
  );
endmodule

// File: tb/test_xdom_req_bridge.sv
module test_xdom_req_bridge;
  logic        srcClk = 1'b0, sysClk = 1'b0;
  logic        srcRstN = 1'b0, sysRstN = 1'b0;
  logic        reqPulse = 1'b0;
  logic [50:0] reqBundle = '0;
  logic        ackPulse;
  logic [31:0] rspWord;
  logic [16:0] sysAddr;
  logic        sysWrStb, sysRdStb;
  logic [31:0] sysWrData, sysRdData;
  int          srcHalf = 5;
  int          errCnt = 0, chkCnt = 0;
  bit          doneFlag = 0;

  always #4 sysClk = ~sysClk;            // 125 MHz
  always #(srcHalf) srcClk = ~srcClk;

  xdom_req_bridge i_xdom_req_bridge (
    .srcClk(srcClk), .srcRstN(srcRstN), .reqPulse(reqPulse), .reqBundle(reqBundle),
    .ackPulse(ackPulse), .rspWord(rspWord), .sysClk(sysClk), .sysRstN(sysRstN),
    .sysAddr(sysAddr), .sysWrStb(sysWrStb), .sysWrData(sysWrData),
    .sysRdStb(sysRdStb), .sysRdData(sysRdData)
  );

  function automatic logic [31:0] rspOf(input logic [16:0] a);
    return {a[15:0], a[16], 15'h1ABC};
  endfunction

  // responder: valid data only in the cycle after a read strobe
  logic rdWindow = 1'b0;
  always @(posedge sysClk) rdWindow <= sysRdStb;
  assign sysRdData = rdWindow ? rspOf(sysAddr) : 32'hDEAD_BEEF;

  // system-side monitor
  int wrCnt = 0, rdCnt = 0, wideStb = 0;
  logic [16:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [31:0] lastWrData = '0;
  logic prevWr = 1'b0, prevRd = 1'b0;
  always @(negedge sysClk) begin
    if (sysWrStb) begin wrCnt++; lastWrAddr = sysAddr; lastWrData = sysWrData; end
    if (sysRdStb) begin rdCnt++; lastRdAddr = sysAddr; end
    if ((sysWrStb && prevWr) || (sysRdStb && prevRd)) wideStb++;
    prevWr = sysWrStb; prevRd = sysRdStb;
  end

  // source-side monitor
  int ackCnt = 0, wideAck = 0;
  logic [31:0] lastRsp = '0;
  logic prevAck = 1'b0;
  always @(negedge srcClk) begin
    if (ackPulse) begin
      ackCnt++; lastRsp = rspWord;
      if (prevAck) wideAck++;
    end
    prevAck = ackPulse;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitAck(input int base);
    for (int i = 0; i < 400 && ackCnt == base; i++) @(negedge srcClk);
    repeat (20) @(negedge srcClk);
    repeat (10) @(negedge sysClk);
  endtask

  task automatic pulseReq(input logic [50:0] b);
    @(negedge srcClk);
    reqBundle = b; reqPulse = 1'b1;
    @(negedge srcClk);
    reqPulse = 1'b0; reqBundle = ~b;   // request word must already be held
  endtask

  localparam logic [58:0] VECS [7] = '{
    {8'd5,  1'b1, 1'b0, 17'h00001, 32'hCAFE_0123},
    {8'd5,  1'b0, 1'b1, 17'h1FFFF, 32'hFFFF_FFFF},
    {8'd13, 1'b1, 1'b0, 17'h10000, 32'h8000_0001},
    {8'd13, 1'b0, 1'b1, 17'h0ABCD, 32'hFFFF_FFFF},
    {8'd2,  1'b0, 1'b1, 17'h15555, 32'hFFFF_FFFF},
    {8'd2,  1'b1, 1'b0, 17'h0AAAA, 32'h5A5A_A5A5},
    {8'd7,  1'b0, 1'b1, 17'h00000, 32'h1234_5678}
  };

  initial begin
    repeat (4) @(negedge sysClk);
    srcRstN = 1'b1; sysRstN = 1'b1;
    repeat (3) @(negedge srcClk);
    // R1
    chk("R1 ackPulse", {31'b0, ackPulse}, 32'd0);
    chk("R1 sysWrStb", {31'b0, sysWrStb}, 32'd0);
    chk("R1 sysRdStb", {31'b0, sysRdStb}, 32'd0);
    chk("R1 sysAddr", {15'b0, sysAddr}, 32'd0);
    chk("R1 rspWord", rspWord, 32'd0);

    for (int v = 0; v < 7; v++) begin
      logic [50:0] b;
      logic wr, rd;
      logic [16:0] a;
      int baseAck, baseWr, baseRd;
      srcHalf = int'(VECS[v][58:51]);
      b = VECS[v][50:0];
      wr = b[50]; rd = b[49]; a = b[48:32];
      repeat (2) @(negedge srcClk);
      baseAck = ackCnt; baseWr = wrCnt; baseRd = rdCnt;
      pulseReq(b);
      waitAck(baseAck);
      // R7 R9: one acknowledge at this clock ratio
      chk($sformatf("R7 R9 ack count vec%0d", v), ackCnt - baseAck, 32'd1);
      chk($sformatf("R3 write strobes vec%0d", v), wrCnt - baseWr, {31'b0, wr});
      chk($sformatf("R4 read strobes vec%0d", v), rdCnt - baseRd, {31'b0, rd});
      if (wr) begin
        chk($sformatf("R2 write addr vec%0d", v), {15'b0, lastWrAddr}, {15'b0, a});
        chk($sformatf("R3 write data vec%0d", v), lastWrData, b[31:0]);
      end
      if (rd) begin
        chk($sformatf("R2 read addr vec%0d", v), {15'b0, lastRdAddr}, {15'b0, a});
        chk($sformatf("R6 response vec%0d", v), lastRsp, rspOf(a));
      end
      // R10 address held at the port long after the strobe
      chk($sformatf("R10 addr hold vec%0d", v), {15'b0, sysAddr}, {15'b0, a});
      // R7 response word held after the acknowledge
      chk($sformatf("R7 rsp hold vec%0d", v), rspWord, lastRsp);
    end

    // R8: second request while the first is outstanding
    begin
      int baseAck, baseWr;
      srcHalf = 2;
      repeat (2) @(negedge srcClk);
      baseAck = ackCnt; baseWr = wrCnt;
      pulseReq({2'b10, 17'h01234, 32'h1111_2222});
      @(negedge srcClk);
      pulseReq({2'b10, 17'h1EEEE, 32'h3333_4444});
      waitAck(baseAck);
      chk("R8 one ack", ackCnt - baseAck, 32'd1);
      chk("R8 one write", wrCnt - baseWr, 32'd1);
      chk("R8 first addr kept", {15'b0, sysAddr}, {15'b0, 17'h01234});
      chk("R8 first data kept", sysWrData, 32'h1111_2222);
      // accepted again after the acknowledge
      baseAck = ackCnt;
      pulseReq({2'b01, 17'h0F0F0, 32'h0});
      waitAck(baseAck);
      chk("R8 later request acked", ackCnt - baseAck, 32'd1);
      chk("R8 later response", lastRsp, rspOf(17'h0F0F0));
    end

    // R5 R7: pulse widths over the whole run
    chk("R5 strobe width", wideStb, 32'd0);
    chk("R7 ack width", wideAck, 32'd0);

    doneFlag = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!doneFlag) begin
      chkCnt++; errCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule